// File: doc/BRIEF.md
# Packed Byte-Lane Shifter

This execution unit treats a wide source word as a row of independent byte lanes and shifts every lane by one common amount. The amount comes either from the low bits of a second operand or from a small immediate field. Several kinds of shift are available:

- plain logical, arithmetic and left shifts;
- right shifts that round to nearest instead of truncating;
- a left shift that clamps to the signed lane limits;
- a two-way clamping shift whose signed amount picks the direction.

Each accepted operation produces a registered result one clock later. A saturation pulse goes with any result in which at least one lane was clamped. The surrounding pipeline decodes the instruction and feeds the operation code. It also keeps the sticky overflow status that the pulse updates.

Top module: `byte_lane_shifter`

## Requirements
- R1: Every lane of `src_a` is processed on its own with the same amount. For operation codes 0 to 5, only `src_b[2:0]` is used as the amount, and all higher bits of `src_b` are ignored.
- R2: Operation code 0 shifts each lane right arithmetically: the sign is replicated and the result truncates toward minus infinity.
- R3: Operation code 1 shifts each lane right logically, filling with zeros.
- R4: Operation code 2 shifts each lane left, filling with zeros and discarding the bits that leave the lane.
- R5: Operation codes 3 (signed) and 4 (unsigned) shift right and then add the last bit shifted out, which rounds half up. An amount of 0 returns the lane unchanged.
- R6: Operation code 5 shifts each signed lane left. When the true product does not fit in the signed byte range, the lane becomes 0x80 if it was negative and 0x7F otherwise, and the lane counts as saturated.
- R7: Operation codes 6 and 7 read `src_b[3:0]` as a two's-complement amount from -8 to +7. A non-negative amount behaves as code 5. A negative amount shifts right arithmetically by its magnitude, with a magnitude of 8 reduced to 7. Code 6 truncates and code 7 rounds as in R5.
- R8: When `imm_en` is high and the operation code is 0, 1 or 2, the amount is `imm_field[2:0]`. If `imm_field[4:3]` equals 01, the operation is promoted to code 3, 4 or 5 respectively; other values of `imm_field[4:3]` keep the plain form. For codes 3 to 7, `imm_en` has no effect.
- R9: `sat_pulse` is the OR of the saturation of all lanes. It is high only in the cycle where `out_valid` is high for that result.
- R10: Results appear one clock after `in_valid`, with `out_valid` high for exactly that cycle. A cycle with `in_valid` low leaves `result` unchanged. Reset clears `out_valid`, `result` and `sat_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issued this cycle |
| op | input | 3 | Operation code 0 to 7 (see R2 to R8) |
| imm_en | input | 1 | Take the amount from `imm_field` |
| imm_field | input | 5 | Immediate: [2:0] amount, [4:3] form select |
| src_a | input | 64 | Packed lane data |
| src_b | input | 64 | Shift operand |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Packed shifted lanes |
| sat_pulse | output | 1 | At least one lane clamped in this result |

## Verification
The bench builds the unit with its defaults: eight lanes of eight bits each and the output register enabled. With these values the true lane extremes 0x80 and 0x7F, the full signed amount range including the -8 clamp, and the one-cycle latency are all reachable. A reference model computes each lane with integer arithmetic. It decides overflow by range-checking the product, not by shifting back. Random operands run across all codes and immediate forms, alongside directed cases for amount 0, single-lane saturation and idle cycles.

// File: rtl/bls_pkg.sv
package bls_pkg;
  typedef enum logic [2:0] {
    OP_SRA      = 3'd0,
    OP_SRL      = 3'd1,
    OP_SLL      = 3'd2,
    OP_SRA_RND  = 3'd3,
    OP_SRL_RND  = 3'd4,
    OP_SLL_SAT  = 3'd5,
    OP_BIDIR    = 3'd6,
    OP_BIDIR_RND= 3'd7
  } op_e;
endpackage

// File: rtl/bls_ctrl.sv
module bls_ctrl
  import bls_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int AMT_W = $clog2(LANE_W)
) (
  input  logic [2:0]       op,
  input  logic             imm_en,
  input  logic [AMT_W+1:0] imm_field,
  input  logic [AMT_W:0]   b_low,
  output logic             dir_left,
  output logic             do_sat,
  output logic             arith,
  output logic             do_rnd,
  output logic [AMT_W-1:0] amt
);
  op_e              eff_op;
  logic [AMT_W:0]   neg_mag;

  assign neg_mag = -b_low;

  always_comb begin
    eff_op   = op_e'(op);
    amt      = b_low[AMT_W-1:0];
    dir_left = 1'b0;
    do_sat   = 1'b0;
    arith    = 1'b0;
    do_rnd   = 1'b0;
    // R8: immediate path only for the three plain codes
    if (imm_en && (op <= 3'd2)) begin
      amt = imm_field[AMT_W-1:0];
      if (imm_field[AMT_W+1:AMT_W] == 2'b01)
        eff_op = op_e'(op + 3'd3);
    end
    unique case (eff_op)
      OP_SRA:     arith = 1'b1;
      OP_SRL:     ;
      OP_SLL:     dir_left = 1'b1;
      OP_SRA_RND: begin arith = 1'b1; do_rnd = 1'b1; end
      OP_SRL_RND: do_rnd = 1'b1;
      OP_SLL_SAT: begin dir_left = 1'b1; do_sat = 1'b1; end
      default: begin
        // R7: signed amount picks direction
        if (!b_low[AMT_W]) begin
          dir_left = 1'b1;
          do_sat   = 1'b1;
        end else begin
          arith  = 1'b1;
          do_rnd = (eff_op == OP_BIDIR_RND);
          amt    = (neg_mag == (AMT_W+1)'(LANE_W)) ? AMT_W'(LANE_W-1)
                                                   : neg_mag[AMT_W-1:0];
        end
      end
    endcase
  end
endmodule

// File: rtl/bls_lane.sv
module bls_lane #(
  parameter int LANE_W = 8,
  localparam int AMT_W = $clog2(LANE_W)
) (
  input  logic [LANE_W-1:0] x,
  input  logic              dir_left,
  input  logic              do_sat,
  input  logic              arith,
  input  logic              do_rnd,
  input  logic [AMT_W-1:0]  amt,
  output logic [LANE_W-1:0] y,
  output logic              ovf
);
  logic signed [LANE_W-1:0] xs, back;
  logic [LANE_W-1:0] rsh, rsh_out, shl, sat_val;
  logic [LANE_W:0]   xe;
  logic              rbit;

  assign xs      = $signed(x);
  assign rsh     = arith ? LANE_W'(xs >>> amt) : (x >> amt);
  assign xe      = {x, 1'b0};
  assign rbit    = xe[amt];
  assign rsh_out = rsh + {{(LANE_W-1){1'b0}}, (do_rnd & rbit)};
  assign shl     = x << amt;
  assign back    = $signed(shl) >>> amt;
  assign ovf     = do_sat && (back != xs);
  assign sat_val = x[LANE_W-1] ? {1'b1, {(LANE_W-1){1'b0}}}
                               : {1'b0, {(LANE_W-1){1'b1}}};
  assign y       = dir_left ? (ovf ? sat_val : shl) : rsh_out;

  always_comb begin
    // R6: a clamped lane holds one of the two signed limits
    if (ovf)
      a_r6_sat_is_limit: assert (y == {1'b1, {(LANE_W-1){1'b0}}} ||
                                 y == {1'b0, {(LANE_W-1){1'b1}}});
    // R5: zero-amount right shift passes the lane through
    if (!dir_left && amt == '0)
      a_r5_zero_amt_pass: assert (y == x);
  end
endmodule

// File: rtl/byte_lane_shifter.sv
module byte_lane_shifter #(
  parameter int LANES   = 8,
  parameter int LANE_W  = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int AMT_W  = $clog2(LANE_W),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic              imm_en,
  input  logic [AMT_W+1:0]  imm_field,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              sat_pulse
);
  logic             dir_left, do_sat, arith, do_rnd;
  logic [AMT_W-1:0] amt;
  logic [DATA_W-1:0] lanes_y;
  logic [LANES-1:0]  lanes_ovf;

  bls_ctrl #(.LANE_W(LANE_W)) u_ctrl (
    .op(op), .imm_en(imm_en), .imm_field(imm_field),
    .b_low(src_b[AMT_W:0]),
    .dir_left(dir_left), .do_sat(do_sat), .arith(arith),
    .do_rnd(do_rnd), .amt(amt)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bls_lane #(.LANE_W(LANE_W)) u_lane (
      .x(src_a[g*LANE_W +: LANE_W]),
      .dir_left(dir_left), .do_sat(do_sat), .arith(arith),
      .do_rnd(do_rnd), .amt(amt),
      .y(lanes_y[g*LANE_W +: LANE_W]),
      .ovf(lanes_ovf[g])
    );
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        result    <= '0;
        sat_pulse <= 1'b0;
      end else begin
        out_valid <= in_valid;
        sat_pulse <= in_valid & (|lanes_ovf);
        if (in_valid) result <= lanes_y;
      end
    end

    // R10: valid follows the issue by one cycle
    a_r10_valid_set: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    a_r10_valid_clear: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    // R10: idle cycles keep the result
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));
    // R9: the pulse only accompanies a valid result
    a_r9_sat_with_valid: assert property (@(posedge clk) disable iff (rst)
      sat_pulse |-> out_valid);
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = lanes_y;
    assign sat_pulse = in_valid & (|lanes_ovf);
  end
endmodule

// File: tb/byte_lane_shifter_test.sv
`timescale 1ns/1ps
module byte_lane_shifter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic        imm_en = 1'b0;
  logic [4:0]  imm_field = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic        out_valid, sat_pulse;
  logic [63:0] result;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [63:0] q_res[$];
  logic        q_sat[$];
  string       q_tag[$];
  logic [63:0] last_res;

  always #2.5 clk = ~clk;

  byte_lane_shifter uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .imm_en(imm_en),
    .imm_field(imm_field), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result), .sat_pulse(sat_pulse)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] lane_ref(int code, int a, int s4, logic [7:0] x);
    int sv, uv, p, m;
    logic s;
    sv = int'($signed(x));
    uv = int'(x);
    s = 1'b0;
    p = 0;
    if (code >= 6) begin
      if (s4 >= 8) s4 = s4 - 16;
      if (s4 >= 0) begin code = 5; a = s4; end
      else begin
        m = -s4;
        if (m == 8) m = 7;
        a = m;
        code = (code == 6) ? 0 : 3;
      end
    end
    case (code)
      0: p = sv >>> a;
      1: p = uv >> a;
      2: p = uv << a;
      3: p = (a == 0) ? sv : ((sv + (1 << (a - 1))) >>> a);
      4: p = (a == 0) ? uv : ((uv + (1 << (a - 1))) >> a);
      default: begin
        p = sv * (1 << a);
        if (p > 127)       begin p = 127;  s = 1'b1; end
        else if (p < -128) begin p = -128; s = 1'b1; end
      end
    endcase
    return {s, p[7:0]};
  endfunction

  task automatic send(logic [2:0] o, logic ie, logic [4:0] imf,
                      logic [63:0] a, logic [63:0] b, string tag_in);
    int code, amt;
    logic [63:0] er;
    logic es;
    logic [8:0] lr;
    string tag;
    code = int'(o);
    amt  = int'(b[2:0]);
    if (ie && o <= 3'd2) begin
      amt = int'(imf[2:0]);
      if (imf[4:3] == 2'b01) code = code + 3;
    end
    es = 1'b0;
    for (int l = 0; l < 8; l++) begin
      lr = lane_ref(code, amt, int'(b[3:0]), a[l*8 +: 8]);
      er[l*8 +: 8] = lr[7:0];
      es = es | lr[8];
    end
    if (tag_in != "") tag = tag_in;
    else if (ie && o <= 3'd2) tag = "R8";
    else case (code)
      0: tag = "R2";
      1: tag = "R3";
      2: tag = "R4";
      3, 4: tag = "R5";
      5: tag = "R6";
      default: tag = "R7";
    endcase
    @(negedge clk);
    in_valid = 1'b1; op = o; imm_en = ie; imm_field = imf;
    src_a = a; src_b = b;
    q_res.push_back(er); q_sat.push_back(es); q_tag.push_back(tag);
    last_res = er;
  endtask

  // R10 / R9: idle cycle leaves result, drops valid and pulse
  task automatic idle_check();
    @(negedge clk);
    in_valid = 1'b0;
    src_a = 64'h5a5a_5a5a_5a5a_5a5a;
    @(negedge clk);
    check("R10 idle valid", {63'd0, out_valid}, 64'd0);
    check("R9 idle pulse", {63'd0, sat_pulse}, 64'd0);
    check("R10 idle hold", result, last_res);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_res.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10: unexpected out_valid, actual 1 expected 0");
      end else begin
        logic [63:0] er;
        logic es;
        string tg;
        er = q_res.pop_front(); es = q_sat.pop_front(); tg = q_tag.pop_front();
        check(tg, result, er);
        check({tg, " R9 flag"}, {63'd0, sat_pulse}, {63'd0, es});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset result", result, 64'd0);
    check("R10 reset pulse", {63'd0, sat_pulse}, 64'd0);

    // R1: high bits of src_b ignored, mixed lanes
    send(3'd0, 0, 5'd0, 64'h807f_0140_ff7e_8102, 64'hffff_ffff_ffff_fffa, "R1");
    send(3'd2, 0, 5'd0, 64'h0123_4567_89ab_cdef, 64'h8000_0000_0000_0009, "R1");
    // R2 / R3 extremes
    send(3'd0, 0, 5'd0, 64'h8080_7f7f_0001_ff80, 64'd7, "R2");
    send(3'd1, 0, 5'd0, 64'h8080_7f7f_0001_ff80, 64'd7, "R3");
    // R5: amount zero and half-up cases
    send(3'd3, 0, 5'd0, 64'h807f_0102_0304_ff81, 64'd0, "R5");
    send(3'd4, 0, 5'd0, 64'hff7f_0103_0507_8081, 64'd1, "R5");
    send(3'd3, 0, 5'd0, 64'hc040_bf3f_8001_fe7f, 64'd7, "R5");
    // R6: single-lane overflow sets pulse
    send(3'd5, 0, 5'd0, 64'h0000_0000_0000_4000, 64'd1, "R6");
    send(3'd5, 0, 5'd0, 64'h7f80_c0bf_3f40_01ff, 64'd1, "R6");
    send(3'd5, 0, 5'd0, 64'h0101_0101_0101_0101, 64'd7, "R6");
    idle_check();
    // R7: signed amount, -8 clamp
    send(3'd6, 0, 5'd0, 64'h8040_7f01_ff80_c03f, 64'h8, "R7");
    send(3'd7, 0, 5'd0, 64'h8040_7f01_ff80_c03f, 64'h8, "R7");
    send(3'd7, 0, 5'd0, 64'h8040_7f01_ff80_c0c1, 64'hf, "R7");
    send(3'd6, 0, 5'd0, 64'h1020_f0e0_0001_7f80, 64'h7, "R7");
    // R8: immediate forms
    send(3'd0, 1, 5'b00_011, 64'h8080_7f7f_0f0f_f0f0, 64'd0, "R8");
    send(3'd0, 1, 5'b01_011, 64'h8480_7c7f_0f0f_f4f0, 64'd0, "R8");
    send(3'd2, 1, 5'b01_010, 64'h2030_1fe0_dfc0_0102, 64'd0, "R8");
    send(3'd1, 1, 5'b10_001, 64'hff01_0203_8081_7f7e, 64'd5, "R8");
    send(3'd6, 1, 5'b01_001, 64'h8040_7f01_ff80_c03f, 64'hc, "R8");
    idle_check();

    for (int i = 0; i < 600; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (i % 7 == 0) ra[15:0] = 16'h807f;
      send(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
           5'($urandom), ra, rb, "");
    end
    idle_check();
    repeat (3) @(negedge clk);
    if (q_res.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R10: actual %0d pending expected 0", q_res.size());
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule